// File: doc/BRIEF.md
# Single-Accumulator Execution Unit

This block executes one-address arithmetic and data-movement commands against a single internal accumulator. Every command carries an opcode and exactly one memory address. The accumulator is always the implicit second source and the destination. A load or an arithmetic command reads one word from an attached synchronous memory and merges it with the accumulator. A store command writes the accumulator to the named word.

Commands arrive over a valid/ready handshake. A command is accepted on a rising clock edge where `cmd_valid` and `cmd_ready` are both high. A small controller then sequences the memory port through four named states:

- `ST_IDLE`: waiting. `cmd_ready` is high, and no memory strobe is active.
- `ST_READ`: the read strobe is driven with the captured address.
- `ST_EXEC`: the returned word is combined and the accumulator is written.
- `ST_WRITE`: the write strobe is driven with the accumulator as data.

The transitions are:

- IDLE→READ on an accepted load, add, sub or mult.
- IDLE→WRITE on an accepted store.
- IDLE→IDLE when no command is offered, or when an accepted opcode is undefined.
- READ→EXEC always.
- EXEC→IDLE always.
- WRITE→IDLE always.

The memory returns read data one cycle after the read strobe. It writes on the clock edge at which the write strobe is high. The accumulator value is visible on `acc_out` at all times. Arithmetic wraps modulo 2^W.

Top module: `acc_exec_unit`

## Requirements
- R1: While reset is held, and in the first cycle after it, `acc_out` is 0, `cmd_ready` is 1, and `mem_rd` and `mem_wr` are 0. An asynchronous active-low reset applied at any time returns the block to this state.
- R2: Opcode 0 (load) sets the accumulator to the memory word at `cmd_addr`.
- R3: Opcode 1 (store) asserts `mem_wr` for one cycle, with `mem_addr` equal to `cmd_addr` and `mem_wdata` equal to the accumulator. The accumulator is left unchanged.
- R4: Opcode 2 (add) sets the accumulator to accumulator + operand, modulo 2^W.
- R5: Opcode 3 (sub) sets the accumulator to accumulator − operand, modulo 2^W. The accumulator is the minuend.
- R6: Opcode 4 (mult) sets the accumulator to the low W bits of accumulator × operand.
- R7: After acceptance, `cmd_ready` is low for exactly two cycles on load/add/sub/mult and for exactly one cycle on store. The new accumulator value appears on `acc_out` as `cmd_ready` returns high.
- R8: Each load/add/sub/mult raises `mem_rd` for exactly one cycle, with `mem_addr` equal to `cmd_addr`, and never raises `mem_wr`. `mem_rd` and `mem_wr` are never high together.
- R9: Opcodes 5, 6 and 7 are accepted without dropping `cmd_ready`, raise no memory strobe, and leave the accumulator unchanged.
- R10: While `cmd_valid` is low, the accumulator holds its value and no memory strobe is raised, whatever `cmd_op` and `cmd_addr` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit idle and able to accept a command |
| cmd_op | input | 3 | Opcode (0 load, 1 store, 2 add, 3 sub, 4 mult) |
| cmd_addr | input | AW | Operand / destination word address |
| mem_rd | output | 1 | Memory read strobe; data is expected one cycle later |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | W | Memory write data |
| mem_rdata | input | W | Memory read data |
| acc_out | output | W | Current accumulator value |

## Verification
The bench targets three arithmetic corner cases:

- An add whose sum passes the top of the word. A design that saturated, or kept a carry, would show a value other than the wrapped sum.
- A sub whose subtrahend is larger than the accumulator. A design with the operands swapped would produce the negated difference.
- A mult with a wide product. A design that kept the wrong half of the product would fail here.

It also checks the handshake edges:

- Commands are issued back to back. A controller that raised ready one cycle early or late, or issued an extra read strobe, would break the cycle counts.
- A store is followed by a load from the same address. A misrouted write address or write data shows up in the value read back.
- Undefined opcodes and idle cycles with a noisy address are offered. These expose a decoder that wrongly strobes memory or alters the accumulator.
- A reset is applied mid-run. It must clear a non-zero accumulator.

// File: rtl/acc_exec_pkg.sv
package acc_exec_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_LOAD  = 3'd0,
        OP_STORE = 3'd1,
        OP_ADD   = 3'd2,
        OP_SUB   = 3'd3,
        OP_MULT  = 3'd4
    } acc_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_EXEC  = 2'd2,
        ST_WRITE = 2'd3
    } acc_state_e;

endpackage

// File: rtl/acc_exec_ctrl.sv
module acc_exec_ctrl
    import acc_exec_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic [OP_W-1:0]     cmd_op,
    input  logic [AW-1:0]       cmd_addr,
    output logic                cmd_ready,
    output logic                mem_rd,
    output logic                mem_wr,
    output logic [AW-1:0]       mem_addr,
    output logic                acc_we,
    output logic [OP_W-1:0]     op_q
);

    acc_state_e          state_q, state_d;
    logic [AW-1:0]       addr_q;
    logic                accept;

    assign accept = cmd_valid && (state_q == ST_IDLE);

    // State register and command capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            op_q    <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                addr_q <= cmd_addr;
                op_q   <= cmd_op;
            end
        end
    end

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_valid) begin
                    case (cmd_op)
                        OP_LOAD, OP_ADD, OP_SUB, OP_MULT: state_d = ST_READ;
                        OP_STORE:                         state_d = ST_WRITE;
                        default:                          state_d = ST_IDLE;
                    endcase
                end
            end
            ST_READ:  state_d = ST_EXEC;
            ST_EXEC:  state_d = ST_IDLE;
            ST_WRITE: state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from the current state
    always_comb begin
        cmd_ready = 1'b0;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        acc_we    = 1'b0;
        mem_addr  = addr_q;
        unique case (state_q)
            ST_IDLE:  cmd_ready = 1'b1;
            ST_READ:  mem_rd    = 1'b1;
            ST_EXEC:  acc_we    = 1'b1;
            ST_WRITE: mem_wr    = 1'b1;
        endcase
    end

endmodule

// File: rtl/acc_exec_alu.sv
module acc_exec_alu
    import acc_exec_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [OP_W-1:0] op,
    input  logic [W-1:0]    acc,
    input  logic [W-1:0]    operand,
    output logic [W-1:0]    result
);

    // All arithmetic is evaluated at width W, so wrap and product truncation are implicit
    always_comb begin
        case (op)
            OP_LOAD: result = operand;
            OP_ADD:  result = acc + operand;
            OP_SUB:  result = acc - operand;
            OP_MULT: result = acc * operand;
            default: result = acc;
        endcase
    end

endmodule

// File: rtl/acc_exec_unit.sv
module acc_exec_unit
    import acc_exec_pkg::*;
#(
    parameter int W  = 16,
    parameter int AW = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    output logic                cmd_ready,
    input  logic [OP_W-1:0]     cmd_op,
    input  logic [AW-1:0]       cmd_addr,
    output logic                mem_rd,
    output logic                mem_wr,
    output logic [AW-1:0]       mem_addr,
    output logic [W-1:0]        mem_wdata,
    input  logic [W-1:0]        mem_rdata,
    output logic [W-1:0]        acc_out
);

    logic              acc_we;
    logic [OP_W-1:0]   op_q;
    logic [W-1:0]      acc_q;
    logic [W-1:0]      alu_res;

    acc_exec_ctrl #(.AW(AW)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .cmd_ready (cmd_ready),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_addr  (mem_addr),
        .acc_we    (acc_we),
        .op_q      (op_q)
    );

    acc_exec_alu #(.W(W)) alu_i (
        .op      (op_q),
        .acc     (acc_q),
        .operand (mem_rdata),
        .result  (alu_res)
    );

    // Accumulator register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (acc_we) begin
            acc_q <= alu_res;
        end
    end

    assign mem_wdata = acc_q;
    assign acc_out   = acc_q;

endmodule

// File: rtl/acc_exec_checker.sv
module acc_exec_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cmd_valid,
    input logic         cmd_ready,
    input logic         mem_rd,
    input logic         mem_wr,
    input logic [W-1:0] acc_out
);

    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr)); // R8

    AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd); // R8

    AST_RD_BUSY_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> !cmd_ready ##1 !cmd_ready ##1 cmd_ready); // R7

    AST_WR_BUSY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> !cmd_ready ##1 cmd_ready); // R7

    AST_WR_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> $stable(acc_out)); // R3

    AST_IDLE_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ready && !cmd_valid) |=> $stable(acc_out)); // R10

    AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !(mem_rd || mem_wr)); // R10

endmodule

bind acc_exec_unit acc_exec_checker #(.W(W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .acc_out   (acc_out)
);

// File: tb/acc_exec_unit_tb.sv
`timescale 1ns/1ps
module acc_exec_unit_tb_top;

    localparam int W     = 16;
    localparam int AW    = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [2:0]    cmd_op = 3'd0;
    logic [AW-1:0] cmd_addr = '0;
    logic          mem_rd, mem_wr;
    logic [AW-1:0] mem_addr;
    logic [W-1:0]  mem_wdata;
    logic [W-1:0]  mem_rdata;
    logic [W-1:0]  acc_out;

    logic [W-1:0]  mem     [DEPTH];
    logic [W-1:0]  ref_mem [DEPTH];
    logic [W-1:0]  ref_acc = '0;

    logic [W-1:0]  exp_q [$];
    string         tag_q [$];

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    acc_exec_unit #(.W(W), .AW(AW)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .acc_out   (acc_out)
    );

    // Synchronous memory model: read data one cycle after the strobe
    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr];
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    // Driver: issues one command, checks the handshake and strobes, pushes the expected accumulator
    task automatic run_cmd(input logic [2:0] op, input logic [AW-1:0] addr, input string tag);
        int busy, rds, wrs, exp_busy;
        logic [AW-1:0] wa, ra;
        logic [W-1:0]  wd;
        logic [W-1:0]  pre;
        busy = 0; rds = 0; wrs = 0; wa = '0; wd = '0; ra = '0;
        pre = ref_acc;
        case (op)
            3'd0: begin ref_acc = ref_mem[addr];           exp_busy = 2; end
            3'd1: begin ref_mem[addr] = ref_acc;           exp_busy = 1; end
            3'd2: begin ref_acc = ref_acc + ref_mem[addr]; exp_busy = 2; end
            3'd3: begin ref_acc = ref_acc - ref_mem[addr]; exp_busy = 2; end
            3'd4: begin ref_acc = ref_acc * ref_mem[addr]; exp_busy = 2; end
            default: exp_busy = 0;
        endcase
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_addr  = addr;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_addr  = ~addr;
        forever begin
            if (mem_rd) begin rds++; ra = mem_addr; end
            if (mem_wr) begin wrs++; wa = mem_addr; wd = mem_wdata; end
            if (cmd_ready) break;
            busy++;
            @(negedge clk);
        end
        chk(busy == exp_busy, {"R7 busy cycles ", tag}, busy, exp_busy);
        if (exp_busy == 2) begin
            chk(rds == 1 && wrs == 0, {"R8 strobes ", tag}, rds * 16 + wrs, 16);
            chk(ra == addr, {"R8 read address ", tag}, ra, addr);
        end else if (exp_busy == 1) begin
            chk(wrs == 1 && rds == 0, {"R3 strobes ", tag}, wrs * 16 + rds, 16);
            chk(wa == addr, {"R3 write address ", tag}, wa, addr);
            chk(wd == pre, {"R3 write data ", tag}, wd, pre);
        end else begin
            chk(rds == 0 && wrs == 0, {"R9 no strobe ", tag}, rds * 16 + wrs, 0);
        end
        exp_q.push_back(ref_acc);
        tag_q.push_back(tag);
    endtask

    // Monitor: compares the accumulator once a command has completed
    initial begin
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0) begin
                logic [W-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(acc_out == e, t, acc_out, e);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            mem[i]     = W'(i * 16'h0137 + 16'h0021);
            ref_mem[i] = W'(i * 16'h0137 + 16'h0021);
        end
        mem[10] = 16'hFFFF; ref_mem[10] = 16'hFFFF;
        mem[11] = 16'h0002; ref_mem[11] = 16'h0002;
        mem[12] = 16'h0005; ref_mem[12] = 16'h0005;
        mem[13] = 16'h1234; ref_mem[13] = 16'h1234;
        mem[14] = 16'h0FED; ref_mem[14] = 16'h0FED;

        repeat (3) @(negedge clk);
        // R1: reset state
        chk(acc_out == 0, "R1 acc in reset", acc_out, 0);
        chk(cmd_ready == 1, "R1 ready in reset", cmd_ready, 1);
        chk(!mem_rd && !mem_wr, "R1 strobes in reset", {mem_rd, mem_wr}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(acc_out == 0 && cmd_ready, "R1 after reset", acc_out, 0);

        run_cmd(3'd0, 8'd10, "R2 load 0xFFFF");
        run_cmd(3'd2, 8'd11, "R4 add wraps");
        run_cmd(3'd3, 8'd12, "R5 sub underflow");
        run_cmd(3'd4, 8'd13, "R6 mult truncated");
        run_cmd(3'd1, 8'd40, "R3 store");
        run_cmd(3'd0, 8'd3,  "R2 load other");
        run_cmd(3'd0, 8'd40, "R2 load stored word");
        run_cmd(3'd4, 8'd14, "R6 mult wide");
        run_cmd(3'd3, 8'd5,  "R5 sub minuend is acc");
        run_cmd(3'd2, 8'd7,  "R4 add");
        run_cmd(3'd5, 8'd12, "R9 undefined op 5");
        run_cmd(3'd6, 8'd13, "R9 undefined op 6");
        run_cmd(3'd7, 8'd40, "R9 undefined op 7");
        run_cmd(3'd1, 8'd41, "R3 store again");

        // R10: idle with noise on op and address
        for (int k = 0; k < 6; k++) begin
            cmd_op   = 3'(k);
            cmd_addr = AW'(k * 9);
            @(negedge clk);
            chk(acc_out == ref_acc, "R10 acc hold when idle", acc_out, ref_acc);
            chk(!mem_rd && !mem_wr, "R10 no strobe when idle", {mem_rd, mem_wr}, 0);
        end
        chk(mem[41] == ref_mem[41], "R3 memory content", mem[41], ref_mem[41]);

        // R1: mid-run reset clears a non-zero accumulator
        rst_n = 1'b0;
        @(negedge clk);
        chk(acc_out == 0, "R1 mid-run reset acc", acc_out, 0);
        chk(cmd_ready == 1, "R1 mid-run reset ready", cmd_ready, 1);
        rst_n = 1'b1;
        ref_acc = '0;
        @(negedge clk);
        run_cmd(3'd2, 8'd11, "R4 add after reset");
        repeat (3) @(negedge clk);
        summary();
    end

endmodule